// File: doc/BRIEF.md
# Signed 32-by-16 Division Unit with Data-Dependent Latency

This unit divides a signed 32-bit dividend by a signed 16-bit divisor. The divisor is sign-extended before use. The unit returns one 32-bit result word and three condition flags: zero, negative and overflow. It also takes a number of clock cycles that depends on the operand values, and it stays busy for exactly that many cycles. This matches the timing a sequential divider of this kind shows inside a processor core. The cycle count is reported on a port when the operation completes.

A transfer starts with a one-cycle `start` pulse while the unit is idle, with both operands present. The unit works on absolute values. It first tests in one step whether the quotient fits in 15 bits. If it fits, it runs a 15-step restoring loop and then waits until its computed latency has elapsed. A zero divisor causes no division. The unit reports a divide-by-zero indication after a short fixed delay, and the caller raises any trap. When an operation ends, `done` pulses for one cycle. The result, flags and cycle count stay on the outputs until the next completion.

Top module: `sdiv_timed`

## Requirements
- R1: A `start` pulse while `busy` is low is accepted at that clock edge, and `busy` is high from the next cycle. A `start` pulse while `busy` is high is ignored: it changes neither the running operation's result nor the busy period.
- R2: `done` is a one-cycle pulse with `busy` low. It rises exactly N clock edges after the accepting edge, where N is the value on `cycles` during that pulse.
- R3: When the true quotient lies in -32767..32767 and the divisor is nonzero, `result[15:0]` holds the quotient truncated toward zero and `result[31:16]` holds the remainder, which carries the sign of the dividend. `flag_v` is 0.
- R4: Without overflow, `flag_z` is 1 exactly when `result[15:0]` is zero, and `flag_n` equals `result[15]`.
- R5: Overflow is flagged when |dividend| / |divisor| exceeds 32767, so a true quotient of -32768 overflows too. `flag_v` is set to 1 and `result` is set to the unmodified dividend. `flag_z` is 1 when the low 16 bits of |dividend| are zero, and `flag_n` is bit 15 of |dividend|.
- R6: An overflowing operation takes exactly 12 cycles.
- R7: A non-overflowing operation takes 12 + 104 cycles, plus 2 if the dividend is negative, plus 2 for each zero among bits 15..1 of the unsigned quotient. It then adds 2 more if the divisor is negative, or else 4 more if the dividend is negative.
- R8: A zero divisor sets `div_zero` to 1 and completes in exactly 4 cycles. `result`, `flag_z`, `flag_n` and `flag_v` are left unchanged. Every other completion clears `div_zero`.
- R9: After reset, `busy`, `done`, `result`, all flags, `div_zero` and `cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| dividend | input | 32 | Two's-complement dividend |
| divisor | input | 16 | Two's-complement divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Remainder (upper half) and quotient (lower half), or the dividend on overflow |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| div_zero | output | 1 | Last operation had a zero divisor |
| cycles | output | 8 | Latency of the last completed operation |

## Verification
The assertions assume that operands are only meaningful on the edge where `start` is accepted, and that `start` may arrive at any time, including while busy. The cycle-range and latency properties rely on `busy` being driven only by the unit. The stimulus holds `start` high for a single cycle per request and changes operands only away from the clock edge. It mixes random full-width operands and right-shifted dividends, so both the overflow and the normal paths occur. Zero divisors and requests issued while busy are injected on purpose.

// File: rtl/sdiv_timed.sv
module sdiv_timed #(
  parameter int CW        = 8,
  parameter int OVF_LAT   = 12,
  parameter int ZDIV_LAT  = 4,
  parameter int BASE_LAT  = 12,
  parameter int LOOP_LAT  = 104
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   dividend,
  input  logic [15:0]   divisor,
  output logic          busy,
  output logic          done,
  output logic [31:0]   result,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_v,
  output logic          div_zero,
  output logic [CW-1:0] cycles
);

  localparam logic [1:0] M_NORM = 2'd0, M_OVF = 2'd1, M_DZ = 2'd2;
  localparam int STEPS = 15;

  wire        dd_neg = dividend[31];
  wire        dv_neg = divisor[15];
  wire [31:0] a_in   = dd_neg ? -dividend : dividend;
  wire [15:0] b_in   = dv_neg ? -divisor : divisor;
  wire        ovf_in = a_in[31:15] >= {1'b0, b_in};
  wire        accept = start && !busy;

  logic [1:0]    mode_q;
  logic [15:0]   rem_q, b_q, alo_q;
  logic [14:0]   low_q, quo_q;
  logic [3:0]    step_q;
  logic [CW-1:0] elapsed_q;
  logic [31:0]   dd_q;
  logic          dd_neg_q, dv_neg_q;

  wire [16:0] trial = {rem_q, low_q[14]};
  wire        fits  = trial >= {1'b0, b_q};
  wire [16:0] diff  = trial - {1'b0, b_q};

  logic [CW-1:0] tgt;
  always_comb begin
    int t;
    t = BASE_LAT + LOOP_LAT + 2;
    for (int i = 1; i < STEPS; i++) t += quo_q[i] ? 0 : 2;
    if (dd_neg_q) t += 2;
    if (dv_neg_q) t += 2;
    else if (dd_neg_q) t += 4;
    tgt = CW'(t);
  end

  wire [15:0] q_u   = {1'b0, quo_q};
  wire [15:0] q_s   = (dd_neg_q ^ dv_neg_q) ? -q_u : q_u;
  wire [15:0] r_s   = dd_neg_q ? -rem_q : rem_q;

  logic finish;
  always_comb begin
    case (mode_q)
      M_OVF:   finish = elapsed_q == CW'(OVF_LAT);
      M_DZ:    finish = elapsed_q == CW'(ZDIV_LAT);
      default: finish = (step_q == 0) && (elapsed_q == tgt);
    endcase
    finish = finish && busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; result <= '0;
      flag_z <= 1'b0; flag_n <= 1'b0; flag_v <= 1'b0;
      div_zero <= 1'b0; cycles <= '0;
      mode_q <= M_NORM; rem_q <= '0; b_q <= '0; alo_q <= '0;
      low_q <= '0; quo_q <= '0; step_q <= '0; elapsed_q <= '0;
      dd_q <= '0; dd_neg_q <= 1'b0; dv_neg_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        elapsed_q <= CW'(1);
        mode_q    <= (b_in == 0) ? M_DZ : (ovf_in ? M_OVF : M_NORM);
        rem_q     <= a_in[30:15];
        low_q     <= a_in[14:0];
        alo_q     <= a_in[15:0];
        quo_q     <= '0;
        step_q    <= 4'(STEPS);
        b_q       <= b_in;
        dd_q      <= dividend;
        dd_neg_q  <= dd_neg;
        dv_neg_q  <= dv_neg && (b_in != 0);
      end else if (busy) begin
        elapsed_q <= elapsed_q + 1'b1;
        if (mode_q == M_NORM && step_q != 0) begin
          rem_q  <= fits ? diff[15:0] : trial[15:0];
          quo_q  <= {quo_q[13:0], fits};
          low_q  <= {low_q[13:0], 1'b0};
          step_q <= step_q - 1'b1;
        end
        if (finish) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          cycles <= elapsed_q;
          case (mode_q)
            M_DZ: div_zero <= 1'b1;
            M_OVF: begin
              div_zero <= 1'b0;
              result   <= dd_q;
              flag_v   <= 1'b1;
              flag_z   <= alo_q == 0;
              flag_n   <= alo_q[15];
            end
            default: begin
              div_zero <= 1'b0;
              result   <= {r_s, q_s};
              flag_v   <= 1'b0;
              flag_z   <= q_s == 0;
              flag_n   <= q_s[15];
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sdiv_timed_chk.sv
module sdiv_timed_chk #(
  parameter int CW       = 8,
  parameter int OVF_LAT  = 12,
  parameter int BASE_LAT = 12,
  parameter int LOOP_LAT = 104
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [31:0]   result,
  input logic          flag_z,
  input logic          flag_n,
  input logic          flag_v,
  input logic          div_zero,
  input logic [CW-1:0] cycles
);

  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (start && !busy) run_cnt <= CW'(1);
    else if (busy) run_cnt <= run_cnt + 1'b1;
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles == $past(run_cnt)));

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && !flag_v) |-> (flag_n == result[15] && flag_z == (result[15:0] == 16'd0)));

  p_ovf_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && flag_v) |-> (cycles == CW'(OVF_LAT)));

  p_norm_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && !flag_v) |->
      (cycles >= CW'(BASE_LAT + LOOP_LAT + 2) && cycles <= CW'(BASE_LAT + LOOP_LAT + 36)));

  p_dz_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> ($stable(result) && $stable(flag_z) && $stable(flag_n) && $stable(flag_v)));

endmodule

bind sdiv_timed sdiv_timed_chk #(.CW(CW), .OVF_LAT(OVF_LAT), .BASE_LAT(BASE_LAT), .LOOP_LAT(LOOP_LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .result(result),
  .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .div_zero(div_zero), .cycles(cycles)
);

// File: tb/sdiv_timed_tb_top.sv
`timescale 1ns/1ps
module sdiv_timed_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, flag_z, flag_n, flag_v, div_zero;
  logic [31:0] result;
  logic [7:0]  cycles;

  int checks = 0;
  int errors = 0;
  int tick = 0;

  logic [31:0] e_res = '0;
  logic        e_z = 1'b0, e_n = 1'b0, e_v = 1'b0;

  always #2 clk = ~clk;

  sdiv_timed dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v), .div_zero(div_zero), .cycles(cycles)
  );

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 150000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp fewer", tick);
      report();
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic expect_op(input logic [31:0] dd, input logic [15:0] dv,
                           output int lat, output logic dz);
    longint sdd, sdv, a, b, q, r, qs, rs;
    int zeros;
    sdd = longint'($signed(dd));
    sdv = longint'($signed(dv));
    dz = (dv == 16'd0);
    if (dz) begin lat = 4; return; end
    a = (sdd < 0) ? -sdd : sdd;
    b = (sdv < 0) ? -sdv : sdv;
    q = a / b;
    r = a % b;
    if (q > 32767) begin
      lat = 12;
      e_res = dd; e_v = 1'b1;
      e_z = (a[15:0] == 16'd0); e_n = a[15];
      return;
    end
    qs = ((sdd < 0) != (sdv < 0)) ? -q : q;
    rs = (sdd < 0) ? -r : r;
    e_res = {rs[15:0], qs[15:0]};
    e_v = 1'b0; e_z = (qs[15:0] == 16'd0); e_n = qs[15];
    zeros = 0;
    for (int i = 1; i < 16; i++) if (!q[i]) zeros++;
    lat = 12 + 104 + 2 * zeros + ((sdd < 0) ? 2 : 0);
    if (sdv < 0) lat += 2;
    else if (sdd < 0) lat += 4;
  endtask

  task automatic run_op(input logic [31:0] dd, input logic [15:0] dv, input bool_busy_poke);
    int lat, n;
    logic dz;
    expect_op(dd, dv, lat, dz);
    @(negedge clk);
    dividend = dd; divisor = dv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after accept", busy, 1'b1);
    n = 1;
    while (!done && n < 400) begin
      if (bool_busy_poke && n == 3) begin
        dividend = 32'h0000_0064; divisor = 16'h0003; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      if (!done) n++;
    end
    start = 1'b0;
    chk("R2 done pulse seen", done, 1'b1);
    chk("R2 busy low at done", busy, 1'b0);
    chk("R2 latency equals cycles", n, cycles);
    chk(dz ? "R8 latency" : (e_v ? "R6 latency" : "R7 latency"), cycles, lat);
    chk("R8 div_zero", div_zero, dz);
    chk(e_v ? "R5 result" : "R3 result", result, e_res);
    chk(e_v ? "R5 flags" : "R4 flags", {flag_z, flag_n}, {e_z, e_n});
    chk("R3 R5 overflow flag", flag_v, e_v);
    @(negedge clk);
    chk("R2 done one cycle", done, 1'b0);
    if (bool_busy_poke) chk("R1 start while busy ignored", busy, 1'b0);
  endtask

  initial begin
    logic [31:0] rd;
    logic [15:0] rv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R9 busy", busy, 1'b0);
    chk("R9 done", done, 1'b0);
    chk("R9 result", result, 32'd0);
    chk("R9 flags", {flag_z, flag_n, flag_v, div_zero}, 4'd0);
    chk("R9 cycles", cycles, 8'd0);
    rst_n = 1'b1;

    run_op(32'd100, 16'd7, 1'b0);
    run_op(-32'sd100, 16'd7, 1'b0);
    run_op(32'd100, -16'sd7, 1'b0);
    run_op(-32'sd100, -16'sd7, 1'b0);
    run_op(-32'sd1, 16'd2, 1'b0);
    run_op(32'd0, 16'd5, 1'b0);
    run_op(32'd32767, 16'd1, 1'b0);
    run_op(-32'sd32767, 16'd1, 1'b0);
    run_op(32'd32768, 16'd1, 1'b0);
    run_op(-32'sd32768, 16'd1, 1'b0);
    run_op(32'h8000_0000, 16'hFFFF, 1'b0);
    run_op(32'h8000_0000, 16'h8000, 1'b0);
    run_op(32'h7FFF_FFFF, 16'h8000, 1'b0);
    run_op(32'd7, 16'd0, 1'b0);
    run_op(-32'sd50000, 16'd0, 1'b0);
    run_op(32'd123456, 16'd1000, 1'b1);

    for (int k = 0; k < 300; k++) begin
      rd = $urandom();
      rv = 16'($urandom());
      case ($urandom_range(0, 3))
        0: rd = $signed(rd) >>> $urandom_range(8, 24);
        1: rv = ($urandom_range(0, 9) == 0) ? 16'd0 : rv;
        2: rd = $signed(rd) >>> 16;
        default: ;
      endcase
      run_op(rd, rv, (k % 37) == 5);
    end

    report();
    $finish;
  end

endmodule